// File: doc/BRIEF.md
# Direction and Polarity GPIO Bank

This block is the register and pin logic of a small general-purpose I/O expander. It has four pins. A simple bus side reaches four byte-wide registers through a 2-bit select, a write strobe with data, and a read strobe. The pin side presents, per pin, a driven value, an output enable and the sampled input level. The serial bus front end, pull-ups and analog drivers sit outside this block.

Software sets each pin's direction with a direction register. It sets the values driven on output pins with an output register. It reads the live pin levels through an input register, which an inversion mask can flip bit by bit. The input register captures the pins at the clock edge of a read strobe, whatever direction each pin has.

A three-state access sequencer orders the bus traffic. **ST_IDLE** is the rest state. **ST_READ** lasts one cycle after an accepted read and presents the read data. **ST_WRITE** lasts one cycle after an accepted write and copies the new register state onto the pin drivers. From any state, a write strobe goes to ST_WRITE (transition *take_write*). Otherwise a read strobe goes to ST_READ (*take_read*). With no strobe the sequencer returns to ST_IDLE (*go_idle*).

Top module: `gpio_expander_bank`

## Requirements
- R1: Register select encoding is 0 = input, 1 = output, 2 = inversion mask, 3 = direction. After reset the direction register reads 8'hFF, the output register reads 8'hFF and the inversion mask reads 8'h00. All pin enables are low and all pin values are 0.
- R2: A direction bit of 0 makes its pin an output (enable high). A direction bit of 1 makes it an input (enable low). A write accepted at clock edge k shows on the pin enables and values after edge k+1.
- R3: An output pin drives its output register bit. An input pin drives value 0, so output register bits have no effect on input pins.
- R4: A read of select 0 returns the pin levels sampled at the strobe edge, each XORed with its inversion mask bit (1 inverts, 0 passes), in bits 3..0. Bits 7..4 always read 1. This holds for output pins and input pins alike.
- R5: A read of the output register returns the stored register value, not the pin levels.
- R6: Bits 7..4 of the output, inversion and direction registers store whatever is written and read back unchanged.
- R7: A write to select 0 changes no register.
- R8: A read strobe at edge k, with no write strobe, raises read-valid with the data for exactly the cycle after edge k. Back-to-back reads give one valid cycle each.
- R9: When the write and read strobes arrive together, the write is performed, the read is dropped and read-valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, zero when read-valid is low |
| rd_valid | output | 1 | Read data valid |
| pin_in | input | 4 | Sampled pin levels |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin output enables |

## Verification
A corrupted direction or output register shows up on pin_oe or pin_out one cycle after the next ST_WRITE cycle. It also shows up on rd_data in the cycle after any read of that register. A wrong inversion mask or a stale input capture appears only on the next read of select 0, in the ST_READ cycle. A sequencer stuck out of ST_READ or ST_WRITE shows at once as a missing or extra rd_valid pulse, or as pins that fail to follow a write.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    typedef enum logic [1:0] {
        SEL_INPUT  = 2'd0,
        SEL_OUTPUT = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;
endpackage

// File: rtl/gpx_access_fsm.sv
module gpx_access_fsm
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       rd_stb,
    output logic       wr_fire,
    output logic       rd_fire,
    output logic       rd_valid,
    output logic       pin_load
);
    acc_state_e state_q, state_d;

    // Writes take priority over reads on the same edge.
    assign wr_fire = wr_stb;
    assign rd_fire = rd_stb & ~wr_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (wr_stb)      state_d = ST_WRITE;  // take_write
                else if (rd_stb) state_d = ST_READ;   // take_read
                else             state_d = ST_IDLE;   // go_idle
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = 1'b0;
        pin_load = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  rd_valid = 1'b1;
            ST_WRITE: pin_load = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int N_PINS = 4,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              rd_fire,
    input  logic [1:0]        sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [N_PINS-1:0] pin_in,
    output logic [REG_W-1:0]  out_q,
    output logic [REG_W-1:0]  dir_q,
    output logic [REG_W-1:0]  rd_word
);
    localparam int SPARE = REG_W - N_PINS;

    logic [REG_W-1:0]  inv_q;
    logic [N_PINS-1:0] cap_q;
    reg_sel_e          rsel_q;
    reg_sel_e          wsel;

    assign wsel = reg_sel_e'(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '1;
            dir_q <= '1;
            inv_q <= '0;
        end else if (wr_fire) begin
            unique case (wsel)
                SEL_INPUT:  ;
                SEL_OUTPUT: out_q <= wr_data;
                SEL_INVERT: inv_q <= wr_data;
                SEL_DIR:    dir_q <= wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '1;
            rsel_q <= SEL_INPUT;
        end else if (rd_fire) begin
            cap_q  <= pin_in;
            rsel_q <= wsel;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (rsel_q)
            SEL_INPUT:  rd_word = {{SPARE{1'b1}}, cap_q ^ inv_q[N_PINS-1:0]};
            SEL_OUTPUT: rd_word = out_q;
            SEL_INVERT: rd_word = inv_q;
            SEL_DIR:    rd_word = dir_q;
            default:    rd_word = '0;
        endcase
    end
endmodule

// File: rtl/gpx_pin_drv.sv
module gpx_pin_drv #(
    parameter int N_PINS = 4,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REG_W-1:0]  out_q,
    input  logic [REG_W-1:0]  dir_q,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_oe[i]  <= 1'b0;
                pin_out[i] <= 1'b0;
            end else if (load) begin
                pin_oe[i]  <= ~dir_q[i];
                pin_out[i] <= ~dir_q[i] & out_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_expander_bank.sv
module gpio_expander_bank #(
    parameter int N_PINS = 4,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_stb,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_stb,
    output logic [REG_W-1:0]  rd_data,
    output logic              rd_valid,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    logic             wr_fire, rd_fire, pin_load;
    logic [REG_W-1:0] out_q, dir_q, rd_word;

    gpx_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wr_fire(wr_fire), .rd_fire(rd_fire), .rd_valid(rd_valid),
        .pin_load(pin_load)
    );

    gpx_regfile #(.N_PINS(N_PINS), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .sel(reg_sel), .wr_data(wr_data), .pin_in(pin_in),
        .out_q(out_q), .dir_q(dir_q), .rd_word(rd_word)
    );

    gpx_pin_drv #(.N_PINS(N_PINS), .REG_W(REG_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .load(pin_load), .out_q(out_q),
        .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign rd_data = rd_valid ? rd_word : '0;
endmodule

// File: rtl/gpio_expander_bank_chk.sv
module gpio_expander_bank_chk #(
    parameter int N_PINS = 4,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              wr_stb,
    input logic [REG_W-1:0]  wr_data,
    input logic              rd_stb,
    input logic [REG_W-1:0]  rd_data,
    input logic              rd_valid,
    input logic [N_PINS-1:0] pin_in,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (pin_oe == '0 && pin_out == '0 && !rd_valid));

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_sel == 2'd3) |=> ##1 (pin_oe == ~$past(wr_data[N_PINS-1:0], 2)));

    // R4
    input_spare_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && reg_sel == 2'd0) |=> (rd_data[REG_W-1:N_PINS] == '1));

    // R8
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |=> rd_valid);

    // R9
    write_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || !rd_stb) |=> !rd_valid);
endmodule

bind gpio_expander_bank gpio_expander_bank_chk #(.N_PINS(N_PINS), .REG_W(REG_W)) u_chk (.*);

// File: tb/gpio_expander_bank_tb.sv
module gpio_expander_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [3:0] pin_in = 4'h0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    gpio_expander_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .rd_valid(rd_valid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Write presented at a falling edge, taken at the next rising edge.
    task automatic bus_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_sel = sel; wr_data = data; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [7:0] data, output logic vld);
        @(negedge clk);
        reg_sel = sel; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        data = rd_data; vld = rd_valid;
    endtask

    task automatic t_reset;
        logic [7:0] d; logic v;
        check("R1 oe", {4'h0, pin_oe}, 8'h00);
        check("R1 out", {4'h0, pin_out}, 8'h00);
        bus_read(2'd3, d, v); check("R1 dir", d, 8'hFF); check("R8 valid", {7'h0, v}, 8'h01);
        bus_read(2'd1, d, v); check("R1 outreg", d, 8'hFF);
        bus_read(2'd2, d, v); check("R1 inv", d, 8'h00);
    endtask

    task automatic t_direction;
        bus_write(2'd1, 8'hA5);
        bus_write(2'd3, 8'hFC);
        @(negedge clk);
        check("R2 oe", {4'h0, pin_oe}, 8'h03);
        check("R3 out", {4'h0, pin_out}, 8'h01);
        bus_write(2'd1, 8'hAA);
        @(negedge clk);
        check("R3 input pins undriven", {4'h0, pin_out}, 8'h02);
        check("R2 oe held", {4'h0, pin_oe}, 8'h03);
    endtask

    task automatic t_polarity;
        logic [7:0] d; logic v;
        pin_in = 4'b1100;
        bus_write(2'd2, 8'h03);
        bus_read(2'd0, d, v); check("R4 partial invert", d, 8'hFF);
        pin_in = 4'b1010;
        bus_write(2'd2, 8'h0F);
        bus_read(2'd0, d, v); check("R4 full invert", d, 8'hF5);
        bus_write(2'd2, 8'h00);
        pin_in = 4'b0110;
        bus_read(2'd0, d, v); check("R4 no invert output pins too", d, 8'hF6);
    endtask

    task automatic t_outreg_readback;
        logic [7:0] d; logic v;
        pin_in = 4'b0101;
        bus_read(2'd1, d, v); check("R5 flop not pin", d, 8'hAA);
    endtask

    task automatic t_spare_bits;
        logic [7:0] d; logic v;
        bus_write(2'd2, 8'hF0);
        bus_read(2'd2, d, v); check("R6 inv spare", d, 8'hF0);
        pin_in = 4'b0110;
        bus_read(2'd0, d, v); check("R6 R4 input spare stays 1", d, 8'hF6);
        bus_write(2'd3, 8'h5C);
        bus_read(2'd3, d, v); check("R6 dir spare", d, 8'h5C);
        bus_write(2'd2, 8'h00);
    endtask

    task automatic t_input_write_ignored;
        logic [7:0] d; logic v;
        bus_write(2'd0, 8'h00);
        bus_read(2'd1, d, v); check("R7 outreg kept", d, 8'hAA);
        bus_read(2'd3, d, v); check("R7 dir kept", d, 8'h5C);
        bus_read(2'd2, d, v); check("R7 inv kept", d, 8'h00);
        pin_in = 4'b0011;
        bus_read(2'd0, d, v); check("R7 input live", d, 8'hF3);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        pin_in = 4'b1001; reg_sel = 2'd0; rd_stb = 1'b1;
        @(negedge clk);
        check("R8 first valid", {7'h0, rd_valid}, 8'h01);
        check("R8 first data", rd_data, 8'hF9);
        pin_in = 4'b0100; reg_sel = 2'd1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R8 second valid", {7'h0, rd_valid}, 8'h01);
        check("R8 second data", rd_data, 8'hAA);
        @(negedge clk);
        check("R8 valid drops", {7'h0, rd_valid}, 8'h00);
    endtask

    task automatic t_collision;
        logic [7:0] d; logic v;
        @(negedge clk);
        reg_sel = 2'd3; wr_data = 8'h0F; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        check("R9 no valid", {7'h0, rd_valid}, 8'h00);
        check("R9 rd_data zero", rd_data, 8'h00);
        @(negedge clk);
        check("R9 write done", {4'h0, pin_oe}, 8'h00);
        bus_read(2'd3, d, v); check("R9 dir written", d, 8'h0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_polarity();
        t_outreg_readback();
        t_spare_bits();
        t_input_write_ignored();
        t_back_to_back();
        t_collision();
        repeat (2) @(negedge clk);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule